// File: doc/BRIEF.md
# Flash Command Engine

This block sequences program and erase operations on an embedded flash array. Software drives a small register bank. It holds a byte target address, a clock divider, a control word, interrupt flags with their enables, and four 32-bit write-data words. When software writes a command bit into the control word, the engine checks the unlock key and the erase code. It then waits a fixed number of divided-clock ticks and applies the change to the array. Finally it clears the command bit and raises a done flag. A command that fails the checks does not touch the array. Instead it raises an access-fault flag.

The array holds lines of four 32-bit words. Programming can only clear bits: each new cell value is the old value ANDed with the data. Erasing sets cells to all ones. A page is a group of `PAGE_LINES` consecutive lines. A second read-only port lets the surrounding logic read any line back.

Top module: `flash_cmd_engine`

## Requirements
- R1: After a synchronous active-high reset, the address, divider, control, interrupt and data registers all read 0, and `irq` is 0.
- R2: A command whose control bits 31:28 do not hold 0x2 leaves the array unchanged. It sets the fault flag (interrupt register bit 1) and clears control bits 2:0.
- R3: A page erase (control bit 2) needs 0x55 in control bits 15:8. A mass erase (bit 1) needs 0xAA in those bits. A command with more than one of bits 2:0 set is rejected. Every rejected command behaves as in R2.
- R4: Control bit 0 with control bit 4 = 0 programs a whole line. The line index is address bits 7:4. Word k of the line becomes its old value AND data word k. Data word k sits at offset 0x30+4k and occupies line bits 32k+31:32k.
- R5: Control bit 0 with control bit 4 = 1 programs one word. The word is selected by address bits 3:2 and becomes its old value AND data word 0. The other words of the line are unchanged.
- R6: A page erase sets the 4 lines of the aligned page that holds the addressed line to all ones. A mass erase sets every line to all ones.
- R7: The divider is held in register 0x04 bits 7:0. A value of N ≥ 1 gives one tick every N clocks, and a value of 0 acts as 1. A program operation waits 3 ticks and an erase waits 6 ticks before the array is changed.
- R8: Control bit 24 reads 1 from the cycle after a command write until the operation ends. When a valid operation ends, the command bits return to 0 and the done flag (interrupt bit 0) is set.
- R9: While bit 24 is 1, writes to the address, control and data registers have no effect.
- R10: In register 0x24, writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A hardware set in the same cycle as a software clear wins.
- R11: Interrupt-register bits 8 and 9 enable the done and fault flags. `irq` is the OR of each flag ANDed with its enable, and it follows the flags on the same clock edge.
- R12: The register map is address 0x00, divider 0x04, control 0x08, interrupt 0x24 and data 0x30–0x3C. Offset 0x40 and all unmapped offsets read 0. Read data appears one cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 7 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | 7 | Register read byte offset |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| irq | output | 1 | Interrupt request |
| arr_rd | input | 1 | Array read-port enable |
| arr_raddr | input | 4 | Array read-port line index |
| arr_rdata | output | 128 | Array line read back, one cycle after the enable |

## Verification
Two things can fall in the same cycle: the engine setting the done flag as an operation ends, and a software write of 0 to the interrupt register. The bench provokes this with its own cycle-level model. It waits until the model is in the final write cycle of a program operation, with the fault flag already set, and issues the clearing write for that very edge. The check expects the fault flag to be cleared, the done flag to remain set, and `irq` to follow on the same edge. A second overlap is exercised when control, address and data writes land while a command is pending. Read-back afterwards must show the old values.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int REG_AW = 7;

  localparam logic [REG_AW-1:0] OFF_ADDR  = 7'h00;
  localparam logic [REG_AW-1:0] OFF_DIV   = 7'h04;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 7'h08;
  localparam logic [REG_AW-1:0] OFF_INTR  = 7'h24;
  localparam logic [REG_AW-1:0] OFF_DATA0 = 7'h30;

  localparam int B_PROG = 0;
  localparam int B_MASS = 1;
  localparam int B_PAGE = 2;
  localparam int B_WORD = 4;
  localparam int B_BUSY = 24;

  localparam logic [3:0] UNLOCK_VAL = 4'h2;
  localparam logic [7:0] CODE_PAGE  = 8'h55;
  localparam logic [7:0] CODE_MASS  = 8'hAA;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_READ, S_WRITE, S_ERASE} seq_state_t;
endpackage

// File: rtl/flash_tick_gen.sv
module flash_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // divider of 0 behaves as 1; >= keeps a shrinking divider from wrapping
  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

  // R7: with a steady divider above 1, ticks never fall on adjacent clocks
  a_r7_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && div > 1) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/flash_line_ram.sv
module flash_line_ram #(
  parameter int AW = 4,
  parameter int W  = 128
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [W-1:0]  b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_cmd_pkg::*;
#(
  parameter int LINE_AW     = 4,
  parameter int WORDS       = 4,
  parameter int PAGE_LINES  = 4,
  parameter int PROG_TICKS  = 3,
  parameter int ERASE_TICKS = 6,
  localparam int LINE_W     = 32 * WORDS,
  localparam int WSEL_W     = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [2:0]         cmd,
  input  logic [3:0]         unlock,
  input  logic [7:0]         code,
  input  logic               word_mode,
  input  logic [LINE_AW-1:0] line_idx,
  input  logic [WSEL_W-1:0]  word_sel,
  input  logic [LINE_W-1:0]  data_line,
  input  logic [LINE_W-1:0]  a_rdata,
  output logic               busy,
  output logic               done_set,
  output logic               fault_set,
  output logic               cmd_clr,
  output logic               a_en,
  output logic               a_we,
  output logic [LINE_AW-1:0] a_addr,
  output logic [LINE_W-1:0]  a_wdata
);
  localparam int TCW = $clog2(ERASE_TICKS + 1);
  localparam logic [LINE_AW-1:0] PMASK = LINE_AW'(PAGE_LINES - 1);

  seq_state_t         st_q;
  logic [TCW-1:0]     tcnt_q;
  logic [LINE_AW-1:0] lcnt_q;
  logic               cmd_ok;
  logic               is_page;
  logic [LINE_AW-1:0] first_line;
  logic [LINE_AW-1:0] last_line;
  logic [TCW-1:0]     dur_m1;
  logic [LINE_W-1:0]  pat;

  assign cmd_ok = (unlock == UNLOCK_VAL) &&
                  ((cmd == 3'b001) ||
                   (cmd == 3'b100 && code == CODE_PAGE) ||
                   (cmd == 3'b010 && code == CODE_MASS));
  assign is_page    = cmd[B_PAGE];
  assign first_line = is_page ? (line_idx & ~PMASK) : '0;
  assign last_line  = is_page ? (line_idx | PMASK) : '1;
  assign dur_m1     = cmd[B_PROG] ? TCW'(PROG_TICKS - 1) : TCW'(ERASE_TICKS - 1);
  assign busy       = (st_q != S_IDLE);

  // AND pattern: full line, or one selected word with ones elsewhere
  always_comb begin
    pat = '1;
    for (int k = 0; k < WORDS; k++) begin
      if (!word_mode)
        pat[32*k +: 32] = data_line[32*k +: 32];
      else if (word_sel == WSEL_W'(k))
        pat[32*k +: 32] = data_line[31:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      tcnt_q <= '0;
      lcnt_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cmd != 3'b000 && cmd_ok) begin
          st_q   <= S_WAIT;
          tcnt_q <= '0;
        end
        S_WAIT: if (tick) begin
          if (tcnt_q == dur_m1) begin
            st_q   <= cmd[B_PROG] ? S_READ : S_ERASE;
            lcnt_q <= first_line;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        S_READ:  st_q <= S_WRITE;
        S_WRITE: st_q <= S_IDLE;
        S_ERASE: if (lcnt_q == last_line) st_q <= S_IDLE;
                 else lcnt_q <= lcnt_q + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    done_set  = 1'b0;
    fault_set = 1'b0;
    cmd_clr   = 1'b0;
    a_en      = 1'b0;
    a_we      = 1'b0;
    a_addr    = line_idx;
    a_wdata   = a_rdata & pat;
    case (st_q)
      S_IDLE: if (cmd != 3'b000 && !cmd_ok) begin
        fault_set = 1'b1;
        cmd_clr   = 1'b1;
      end
      S_READ: a_en = 1'b1;
      S_WRITE: begin
        a_en     = 1'b1;
        a_we     = 1'b1;
        done_set = 1'b1;
        cmd_clr  = 1'b1;
      end
      S_ERASE: begin
        a_en    = 1'b1;
        a_we    = 1'b1;
        a_addr  = lcnt_q;
        a_wdata = '1;
        if (lcnt_q == last_line) begin
          done_set = 1'b1;
          cmd_clr  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // R2 / R3: a rejected command never leaves the idle state
  a_r2_reject_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && cmd != 3'b000 && !cmd_ok) |=> (st_q == S_IDLE));

  // R6: erase walk stays inside the selected range
  a_r6_erase_in_range: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_ERASE) |-> (lcnt_q >= first_line && lcnt_q <= last_line));
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int LINE_AW     = 4,
  parameter int WORDS       = 4,
  parameter int PAGE_LINES  = 4,
  parameter int PROG_TICKS  = 3,
  parameter int ERASE_TICKS = 6,
  parameter int DIV_W       = 8,
  localparam int LINE_W     = 32 * WORDS,
  localparam int WSEL_W     = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_waddr,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_raddr,
  output logic [31:0]        reg_rdata,
  output logic               irq,
  input  logic               arr_rd,
  input  logic [LINE_AW-1:0] arr_raddr,
  output logic [LINE_W-1:0]  arr_rdata
);
  logic [31:0]        addr_q;
  logic [31:0]        ctrl_q;
  logic [DIV_W-1:0]   div_q;
  logic [1:0]         ie_q, flag_q, ie_d, flag_d, keep;
  logic [31:0]        data_q [WORDS];
  logic [LINE_W-1:0]  data_line;
  logic [31:0]        rd_val;
  logic               tick, busy, done_set, fault_set, cmd_clr, pend;
  logic               wr_open, wr_intr;
  logic               a_en, a_we;
  logic [LINE_AW-1:0] a_addr;
  logic [LINE_W-1:0]  a_wdata, a_rdata;

  function automatic logic hits_data(input logic [REG_AW-1:0] a);
    return (a >= OFF_DATA0) && (a < OFF_DATA0 + REG_AW'(4 * WORDS)) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [WSEL_W-1:0] data_slot(input logic [REG_AW-1:0] a);
    logic [REG_AW-1:0] off;
    off = a - OFF_DATA0;
    return off[2 +: WSEL_W];
  endfunction

  assign pend    = busy | (|ctrl_q[2:0]);
  assign wr_open = reg_wr & ~pend;
  assign wr_intr = reg_wr && (reg_waddr == OFF_INTR);
  assign keep    = wr_intr ? reg_wdata[1:0] : 2'b11;
  assign flag_d  = (flag_q & keep) | {fault_set, done_set};
  assign ie_d    = wr_intr ? reg_wdata[9:8] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ctrl_q <= '0;
      div_q  <= '0;
      ie_q   <= '0;
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_open && reg_waddr == OFF_ADDR) addr_q <= reg_wdata;
      if (reg_wr && reg_waddr == OFF_DIV)   div_q  <= reg_wdata[DIV_W-1:0];
      if (wr_open && reg_waddr == OFF_CTRL) ctrl_q <= reg_wdata & ~(32'h1 << B_BUSY);
      else if (cmd_clr)                     ctrl_q[2:0] <= 3'b000;
      ie_q   <= ie_d;
      flag_q <= flag_d;
      irq    <= |(flag_d & ie_d);
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) data_q[k] <= '0;
      else if (wr_open && hits_data(reg_waddr) && data_slot(reg_waddr) == WSEL_W'(k))
        data_q[k] <= reg_wdata;
    end
    assign data_line[32*k +: 32] = data_q[k];
  end

  always_comb begin
    rd_val = '0;
    if (reg_raddr == OFF_ADDR)      rd_val = addr_q;
    else if (reg_raddr == OFF_DIV)  rd_val = {{(32-DIV_W){1'b0}}, div_q};
    else if (reg_raddr == OFF_CTRL) begin
      rd_val         = ctrl_q;
      rd_val[B_BUSY] = pend;
    end else if (reg_raddr == OFF_INTR) begin
      rd_val[9:8] = ie_q;
      rd_val[1:0] = flag_q;
    end else if (hits_data(reg_raddr)) rd_val = data_q[data_slot(reg_raddr)];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  flash_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk (clk), .rst (rst), .div (div_q), .tick (tick)
  );

  flash_seq #(
    .LINE_AW(LINE_AW), .WORDS(WORDS), .PAGE_LINES(PAGE_LINES),
    .PROG_TICKS(PROG_TICKS), .ERASE_TICKS(ERASE_TICKS)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmd       (ctrl_q[2:0]),
    .unlock    (ctrl_q[31:28]),
    .code      (ctrl_q[15:8]),
    .word_mode (ctrl_q[B_WORD]),
    .line_idx  (addr_q[WSEL_W+2 +: LINE_AW]),
    .word_sel  (addr_q[2 +: WSEL_W]),
    .data_line (data_line),
    .a_rdata   (a_rdata),
    .busy      (busy),
    .done_set  (done_set),
    .fault_set (fault_set),
    .cmd_clr   (cmd_clr),
    .a_en      (a_en),
    .a_we      (a_we),
    .a_addr    (a_addr),
    .a_wdata   (a_wdata)
  );

  flash_line_ram #(.AW(LINE_AW), .W(LINE_W)) i_ram (
    .clk     (clk),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_en    (arr_rd),
    .b_addr  (arr_raddr),
    .b_rdata (arr_rdata)
  );

  // R9: a control write during a pending operation leaves the register alone
  a_r9_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    (pend && reg_wr && reg_waddr == OFF_CTRL && !cmd_clr) |=> $stable(ctrl_q));

  // R8: completion clears the command bits and raises done
  a_r8_done_clears_cmd: assert property (@(posedge clk) disable iff (rst)
    done_set |=> (ctrl_q[2:0] == 3'b000 && flag_q[0]));

  // R10: a hardware fault set is never lost to a same-cycle software clear
  a_r10_fault_wins: assert property (@(posedge clk) disable iff (rst)
    fault_set |=> flag_q[1]);

  // R2: the array is never written while no command is pending
  a_r2_write_needs_pend: assert property (@(posedge clk) disable iff (rst)
    a_we |-> pend);
endmodule

// File: tb/test_flash_cmd_engine.sv
`timescale 1ns/1ps
module test_flash_cmd_engine;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr = 1'b0;
  logic [6:0]   reg_waddr = '0;
  logic [31:0]  reg_wdata = '0;
  logic         reg_rd = 1'b0;
  logic [6:0]   reg_raddr = '0;
  logic [31:0]  reg_rdata;
  logic         irq;
  logic         arr_rd = 1'b0;
  logic [3:0]   arr_raddr = '0;
  logic [127:0] arr_rdata;

  always #2 clk = ~clk;

  flash_cmd_engine i_flash_cmd_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq),
    .arr_rd(arr_rd), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
  );

  int errors = 0;
  int checks = 0;
  bit run = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // behavioural model state
  logic [31:0] m_addr, m_ctrl;
  logic [7:0]  m_div;
  logic [1:0]  m_ie, m_flag;
  logic [31:0] m_data [4];
  logic [31:0] m_mem [64];
  int          m_st, m_tcnt, m_lc, m_tc;
  logic        m_irq;
  logic [31:0] e_rd;
  bit          e_rv;
  string       e_tag;
  logic [127:0] e_arr;
  bit          e_av;
  string       e_atag;

  task automatic model_step();
    int lim, line, base, last, dur;
    bit tk, pend, ok, ds, fs, clr;
    logic [2:0] cmd;
    logic [1:0] wm;
    lim  = (m_div == 0) ? 0 : m_div - 1;
    tk   = (m_tc >= lim);
    pend = (m_st != 0) || (m_ctrl[2:0] != 0);
    cmd  = m_ctrl[2:0];
    line = m_addr[7:4];
    e_rv = reg_rd;
    e_tag = cur_tag;
    if (reg_rd) begin
      case (reg_raddr)
        7'h00: e_rd = m_addr;
        7'h04: e_rd = {24'h0, m_div};
        7'h08: e_rd = m_ctrl | (32'(pend) << 24);
        7'h24: e_rd = {22'h0, m_ie, 6'h0, m_flag};
        7'h30, 7'h34, 7'h38, 7'h3C: e_rd = m_data[(reg_raddr - 7'h30) >> 2];
        default: e_rd = 32'h0;
      endcase
    end
    e_av = arr_rd;
    e_atag = cur_tag;
    if (arr_rd)
      e_arr = {m_mem[arr_raddr*4+3], m_mem[arr_raddr*4+2], m_mem[arr_raddr*4+1], m_mem[arr_raddr*4]};
    ds = 0; fs = 0; clr = 0;
    ok = (m_ctrl[31:28] == 4'h2) &&
         (cmd == 3'b001 || (cmd == 3'b100 && m_ctrl[15:8] == 8'h55) ||
          (cmd == 3'b010 && m_ctrl[15:8] == 8'hAA));
    dur  = cmd[0] ? 3 : 6;
    base = cmd[2] ? (line & ~3) : 0;
    last = cmd[2] ? base + 3 : 15;
    case (m_st)
      0: if (cmd != 0) begin
           if (ok) begin m_st = 1; m_tcnt = 0; end
           else begin fs = 1; clr = 1; end
         end
      1: if (tk) begin
           if (m_tcnt == dur - 1) begin
             if (cmd == 3'b001) m_st = 2;
             else begin m_st = 4; m_lc = base; end
           end else m_tcnt++;
         end
      2: m_st = 3;
      3: begin
           if (m_ctrl[4]) m_mem[line*4 + m_addr[3:2]] &= m_data[0];
           else for (int k = 0; k < 4; k++) m_mem[line*4 + k] &= m_data[k];
           ds = 1; clr = 1; m_st = 0;
         end
      4: begin
           for (int k = 0; k < 4; k++) m_mem[m_lc*4 + k] = 32'hFFFF_FFFF;
           if (m_lc == last) begin ds = 1; clr = 1; m_st = 0; end
           else m_lc++;
         end
      default: m_st = 0;
    endcase
    m_tc = tk ? 0 : m_tc + 1;
    wm = 2'b11;
    if (reg_wr) begin
      if (!pend && reg_waddr == 7'h00) m_addr = reg_wdata;
      if (reg_waddr == 7'h04) m_div = reg_wdata[7:0];
      if (!pend && reg_waddr == 7'h08) m_ctrl = reg_wdata & 32'hFEFF_FFFF;
      if (!pend && reg_waddr >= 7'h30 && reg_waddr <= 7'h3C && reg_waddr[1:0] == 2'b00)
        m_data[(reg_waddr - 7'h30) >> 2] = reg_wdata;
      if (reg_waddr == 7'h24) begin m_ie = reg_wdata[9:8]; wm = reg_wdata[1:0]; end
    end
    if (clr) m_ctrl[2:0] = 3'b000;
    m_flag = (m_flag & wm) | {fs, ds};
    m_irq  = |(m_flag & m_ie);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_ctrl = 0; m_div = 0; m_ie = 0; m_flag = 0; m_irq = 0;
      for (int k = 0; k < 4; k++) m_data[k] = 0;
      m_st = 0; m_tcnt = 0; m_lc = 0; m_tc = 0; e_rv = 0; e_av = 0;
    end else begin
      model_step();
    end
  end

  task automatic chk32(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run && !rst) begin
      chk32("R11 irq", {31'h0, irq}, {31'h0, m_irq});
      if (e_rv) chk32(e_tag, reg_rdata, e_rd);
      if (e_av) begin
        checks++;
        if (arr_rdata !== e_arr) begin
          errors++;
          $display("FAIL %s line: got %h expected %h", e_atag, arr_rdata, e_arr);
        end
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    reg_wr = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    cur_tag = tag; reg_rd = 1; reg_raddr = a;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic line_chk(input int l, input string tag);
    cur_tag = tag; arr_rd = 1; arr_raddr = 4'(l);
    @(negedge clk);
    arr_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    run = 1;
    rd(7'h08, "R1"); rd(7'h24, "R1"); rd(7'h00, "R1"); rd(7'h04, "R1"); rd(7'h30, "R1");
    wr(7'h24, 32'h300);
    rd(7'h24, "R12");
    // mass erase initialises the array
    wr(7'h08, 32'h2000_AA02);
    rd(7'h08, "R8");
    idle(40);
    line_chk(0, "R6"); line_chk(15, "R6");
    wr(7'h24, 32'h300);
    // full-line program
    wr(7'h30, 32'hFFFF_0000); wr(7'h34, 32'h0F0F_0F0F);
    wr(7'h38, 32'h1234_5678); wr(7'h3C, 32'hA5A5_A5A5);
    wr(7'h00, 32'h10);
    wr(7'h08, 32'h2000_0001);
    rd(7'h08, "R8"); rd(7'h08, "R8"); rd(7'h08, "R8");
    idle(10);
    rd(7'h08, "R8");
    line_chk(1, "R4"); line_chk(0, "R4");
    wr(7'h24, 32'h300);
    rd(7'h24, "R10");
    // single word program
    wr(7'h30, 32'h00FF_00FF); wr(7'h00, 32'h18);
    wr(7'h08, 32'h2000_0011);
    idle(10);
    line_chk(1, "R5");
    wr(7'h24, 32'h300);
    // wrong unlock key
    wr(7'h08, 32'h3000_0001);
    idle(3);
    rd(7'h24, "R2"); rd(7'h08, "R2"); line_chk(1, "R2");
    wr(7'h24, 32'h300);
    // wrong erase code, then several command bits
    wr(7'h08, 32'h2000_AA04);
    idle(3);
    rd(7'h24, "R3");
    wr(7'h24, 32'h300);
    wr(7'h08, 32'h2000_5505);
    idle(3);
    rd(7'h24, "R3"); line_chk(1, "R3");
    // writing 1 keeps a flag, writing 0 clears it
    wr(7'h24, 32'h302);
    rd(7'h24, "R10");
    wr(7'h24, 32'h301);
    rd(7'h24, "R10");
    // irq masked when enables are 0
    wr(7'h24, 32'h000);
    wr(7'h08, 32'h7000_0001);
    idle(3);
    rd(7'h24, "R11");
    wr(7'h24, 32'h300);
    // program line 5 to zeros
    for (int k = 0; k < 4; k++) wr(7'(7'h30 + 4*k), 32'h0);
    wr(7'h00, 32'h50); wr(7'h08, 32'h2000_0001);
    idle(10);
    wr(7'h24, 32'h300);
    // page erase; writes while pending must be ignored
    wr(7'h00, 32'h14); wr(7'h08, 32'h2000_5504);
    wr(7'h00, 32'h70); wr(7'h30, 32'h1111_1111); wr(7'h08, 32'h2000_0001);
    rd(7'h00, "R9"); rd(7'h30, "R9"); rd(7'h08, "R9");
    idle(20);
    line_chk(0, "R6"); line_chk(1, "R6"); line_chk(3, "R6"); line_chk(5, "R6");
    wr(7'h24, 32'h300);
    // divided tick timing
    wr(7'h04, 32'h3);
    rd(7'h04, "R12");
    wr(7'h30, 32'hF0F0_F0F0); wr(7'h00, 32'h20); wr(7'h08, 32'h2000_0001);
    for (int k = 0; k < 16; k++) rd(7'h08, "R7");
    idle(5);
    line_chk(2, "R7");
    wr(7'h04, 32'h0);
    wr(7'h24, 32'h300);
    // done set collides with a software clear
    wr(7'h08, 32'h1000_0001);
    idle(3);
    wr(7'h00, 32'h30); wr(7'h08, 32'h2000_0001);
    while (m_st != 3) @(negedge clk);
    wr(7'h24, 32'h300);
    rd(7'h24, "R10");
    line_chk(3, "R10");
    // map corners
    rd(7'h40, "R12"); rd(7'h0C, "R12"); rd(7'h3C, "R12"); rd(7'h2C, "R12");
    idle(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule